// File: doc/BRIEF.md
# Dithered Pulse-Width DAC, 14-bit

This block produces a 14-bit pulse-width modulated output. An external RC filter turns that output into an analog control voltage. The 14-bit code is split into two parts:

- an 8-bit coarse part, which sets the high time of a short sub-period of 256 time units;
- a 6-bit fine part, which lengthens selected sub-periods by one extra unit.

Sixty-four sub-periods make one frame. The average high time over a frame therefore resolves to one part in 16384. Because the fine bits are spread evenly across the frame, the ripple stays at the sub-period rate and not at the frame rate.

Software writes the coarse byte first and the fine bits second. The coarse write only lands in a holding register. The fine write transfers both parts together into a staged code, and the coarse readback returns that staged value. A running output adopts the staged code only at the next frame boundary, so a frame never mixes two codes.

A stop input halts generation. While it is high, the counters are cleared, the output sits at its idle level and the staged code is copied straight into the active code. A polarity input inverts the output.

Top module: `dither_pwm_dac`

## Requirements
- R1: After reset, `dac_o` is 0 and `coarse_rdata_o` is 0.
- R2: One time unit lasts TICK_DIV clock cycles. A sub-period lasts 256 units, and a frame lasts 64 sub-periods.
- R3: While running, each sub-period starts with the output at its active level. The output stays active for a number of units equal to the coarse value, plus one unit if that sub-period is stretched.
- R4: Sub-period index m runs from 0 to 63. For m in 1 to 63, let j be the position of the lowest set bit of m. Sub-period m is stretched when fine bit (5-j) is 1. Sub-period 0 is never stretched. As a result, fine bit k stretches 2^k sub-periods.
- R5: For a coarse value below 255, the active time summed over one frame equals 64·coarse + fine units.
- R6: The output is never active for a whole sub-period. With a coarse value of 255, a stretched sub-period is still active for 255 units.
- R7: A coarse write that is not followed by a fine write changes neither the readback nor the output.
- R8: A fine write copies the held coarse byte and the written fine bits into the staged code. `coarse_rdata_o` shows the staged coarse byte from the following cycle.
- R9: While running, the active code takes the staged value only at the end of unit 255 of sub-period 63. The frame in progress finishes with the old code.
- R10: While `count_stop_i` is 1, the counters are held at zero and the staged code loads into the active code. One cycle after a stop, `dac_o` equals `polarity_i`.
- R11: When `polarity_i` is 1, the output is the bitwise inverse of the waveform produced with `polarity_i` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coarse_we_i | input | 1 | Write strobe for the coarse holding byte |
| coarse_wdata_i | input | 8 | Coarse byte to hold |
| fine_we_i | input | 1 | Write strobe for the fine bits; triggers the transfer to the staged code |
| fine_wdata_i | input | 6 | Fine bits |
| coarse_rdata_o | output | 8 | Readback of the staged coarse byte |
| count_stop_i | input | 1 | 1 stops generation; 0 runs |
| polarity_i | input | 1 | 1 inverts the output |
| dac_o | output | 1 | Pulse-width output |

## Verification
The checker tests the following on every cycle:
- the output returns to its idle level after a stop;
- the counters restart from zero after a stop or a frame end;
- the active code changes only at a frame end or while stopped;
- a lone coarse write leaves the readback unchanged;
- the active level never lasts a full sub-period.

Some properties can only be shown by the bench's measured frames:
- the exact active time of each sub-period;
- the stretch pattern produced by the lowest-set-bit decode;
- the frame total of 64·coarse + fine;
- a mid-frame update that takes effect exactly one frame later.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int unsigned COARSE_W = 8;
  localparam int unsigned FINE_W   = 6;
  localparam int unsigned CODE_W   = COARSE_W + FINE_W;

  typedef logic [COARSE_W-1:0] coarse_t;
  typedef logic [FINE_W-1:0]   fine_t;

  // lowest set bit j of the sub index selects fine bit FINE_W-1-j
  function automatic logic stretch_sel(input fine_t sub, input fine_t fine);
    logic s;
    s = 1'b0;
    for (int j = FINE_W - 1; j >= 0; j--) begin
      if (sub[j]) s = fine[FINE_W-1-j];
    end
    return s;
  endfunction
endpackage

// File: rtl/dac_timebase.sv
module dac_timebase #(
  parameter int unsigned TICK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pre_q <= '0;
    else if (!run_i || pre_q == LAST) pre_q <= '0;
    else                              pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && (pre_q == LAST);
endmodule

// File: rtl/dac_data_latch.sv
module dac_data_latch
  import dac_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    coarse_we_i,
  input  coarse_t coarse_wdata_i,
  input  logic    fine_we_i,
  input  fine_t   fine_wdata_i,
  input  logic    load_i,
  output coarse_t hold_c_o,
  output coarse_t staged_c_o,
  output coarse_t active_c_o,
  output fine_t   active_f_o
);
  coarse_t hold_c_q, staged_c_q, active_c_q;
  fine_t   staged_f_q, active_f_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_c_q   <= '0;
      staged_c_q <= '0;
      staged_f_q <= '0;
      active_c_q <= '0;
      active_f_q <= '0;
    end else begin
      if (coarse_we_i) hold_c_q <= coarse_wdata_i;
      if (fine_we_i) begin
        staged_c_q <= hold_c_q;
        staged_f_q <= fine_wdata_i;
      end
      if (load_i) begin
        active_c_q <= staged_c_q;
        active_f_q <= staged_f_q;
      end
    end
  end

  assign hold_c_o   = hold_c_q;
  assign staged_c_o = staged_c_q;
  assign active_c_o = active_c_q;
  assign active_f_o = active_f_q;
endmodule

// File: rtl/dac_wave.sv
module dac_wave
  import dac_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    run_i,
  input  logic    tick_i,
  input  logic    polarity_i,
  input  coarse_t coarse_i,
  input  fine_t   fine_i,
  output coarse_t slot_o,
  output fine_t   sub_o,
  output logic    frame_end_o,
  output logic    dac_o
);
  localparam logic [COARSE_W:0] MAX_HI = {1'b0, {COARSE_W{1'b1}}};

  coarse_t slot_q;
  fine_t   sub_q;
  logic    dac_q;
  logic    slot_last;
  logic [COARSE_W:0] hi_sum, hi_len;
  logic    raw;

  assign slot_last   = &slot_q;
  assign frame_end_o = tick_i && slot_last && (&sub_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      sub_q  <= '0;
    end else if (!run_i) begin
      slot_q <= '0;
      sub_q  <= '0;
    end else if (tick_i) begin
      slot_q <= slot_q + 1'b1;
      if (slot_last) sub_q <= sub_q + 1'b1;
    end
  end

  // a full sub-period high is clipped to one unit short
  always_comb begin
    hi_sum = {1'b0, coarse_i} + {{COARSE_W{1'b0}}, stretch_sel(sub_q, fine_i)};
    hi_len = (hi_sum > MAX_HI) ? MAX_HI : hi_sum;
    raw    = {1'b0, slot_q} < hi_len;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dac_q <= 1'b0;
    else if (!run_i) dac_q <= polarity_i;
    else             dac_q <= raw ^ polarity_i;
  end

  assign slot_o = slot_q;
  assign sub_o  = sub_q;
  assign dac_o  = dac_q;
endmodule

// File: rtl/dither_pwm_dac.sv
module dither_pwm_dac
  import dac_pkg::*;
#(
  parameter int unsigned TICK_DIV = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                coarse_we_i,
  input  logic [COARSE_W-1:0] coarse_wdata_i,
  input  logic                fine_we_i,
  input  logic [FINE_W-1:0]   fine_wdata_i,
  output logic [COARSE_W-1:0] coarse_rdata_o,
  input  logic                count_stop_i,
  input  logic                polarity_i,
  output logic                dac_o
);
  logic    run, tick, frame_end;
  coarse_t hold_c, staged_c, active_c, slot;
  fine_t   active_f, sub;

  assign run = !count_stop_i;

  dac_timebase #(.TICK_DIV(TICK_DIV)) i_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  dac_data_latch i_latch (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .coarse_we_i    (coarse_we_i),
    .coarse_wdata_i (coarse_wdata_i),
    .fine_we_i      (fine_we_i),
    .fine_wdata_i   (fine_wdata_i),
    .load_i         (count_stop_i || frame_end),
    .hold_c_o       (hold_c),
    .staged_c_o     (staged_c),
    .active_c_o     (active_c),
    .active_f_o     (active_f)
  );

  dac_wave i_wave (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .tick_i      (tick),
    .polarity_i  (polarity_i),
    .coarse_i    (active_c),
    .fine_i      (active_f),
    .slot_o      (slot),
    .sub_o       (sub),
    .frame_end_o (frame_end),
    .dac_o       (dac_o)
  );

  assign coarse_rdata_o = staged_c;
endmodule

// File: rtl/dac_checker.sv
module dac_checker
  import dac_pkg::*;
#(
  parameter int unsigned TICK_DIV = 2
) (
  input logic    clk_i,
  input logic    rst_ni,
  input logic    coarse_we_i,
  input logic    fine_we_i,
  input coarse_t coarse_rdata_o,
  input logic    count_stop_i,
  input logic    polarity_i,
  input logic    dac_o,
  input coarse_t slot,
  input fine_t   sub,
  input logic    frame_end,
  input coarse_t active_c,
  input fine_t   active_f
);
  localparam int unsigned FULL = (1 << COARSE_W) * TICK_DIV;
  localparam int unsigned CW   = $clog2(FULL + 1);

  logic          past_ok;
  logic [CW-1:0] act_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               act_run <= '0;
    else if (count_stop_i || dac_o == polarity_i) act_run <= '0;
    else if (act_run != CW'(FULL))             act_run <= act_run + 1'b1;
  end

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(count_stop_i) |-> dac_o == $past(polarity_i));

  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(count_stop_i) |-> slot == '0 && sub == '0);

  assert_frame_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(frame_end) |-> slot == '0 && sub == '0);

  assert_code_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$stable({active_c, active_f}) |-> $past(frame_end || count_stop_i));

  assert_lone_coarse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(coarse_we_i && !fine_we_i) |-> $stable(coarse_rdata_o));

  assert_no_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_run < CW'(FULL));
endmodule

bind dither_pwm_dac dac_checker #(.TICK_DIV(TICK_DIV)) i_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .coarse_we_i    (coarse_we_i),
  .fine_we_i      (fine_we_i),
  .coarse_rdata_o (coarse_rdata_o),
  .count_stop_i   (count_stop_i),
  .polarity_i     (polarity_i),
  .dac_o          (dac_o),
  .slot           (slot),
  .sub            (sub),
  .frame_end      (frame_end),
  .active_c       (active_c),
  .active_f       (active_f)
);

// File: tb/test_dither_pwm_dac.sv
`timescale 1ns/1ps
module test_dither_pwm_dac;
  localparam int FRAME = 16384;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       coarse_we_i = 1'b0;
  logic [7:0] coarse_wdata_i = '0;
  logic       fine_we_i = 1'b0;
  logic [5:0] fine_wdata_i = '0;
  logic [7:0] coarse_rdata_o;
  logic       count_stop_i = 1'b1;
  logic       polarity_i = 1'b0;
  logic       dac_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk_i = ~clk_i;

  dither_pwm_dac #(.TICK_DIV(1)) i_dither_pwm_dac (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .coarse_we_i    (coarse_we_i),
    .coarse_wdata_i (coarse_wdata_i),
    .fine_we_i      (fine_we_i),
    .fine_wdata_i   (fine_wdata_i),
    .coarse_rdata_o (coarse_rdata_o),
    .count_stop_i   (count_stop_i),
    .polarity_i     (polarity_i),
    .dac_o          (dac_o)
  );

  function automatic int exp_sub(int dh, int dl, int m);
    int st = 0;
    if (m != 0)
      for (int j = 5; j >= 0; j--)
        if (m[j]) st = (dl >> (5 - j)) & 1;
    return (dh + st > 255) ? 255 : dh + st;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // starts and ends at a negedge, stopped
  task automatic load(int dh, int dl);
    count_stop_i = 1'b1;
    coarse_wdata_i = 8'(dh); coarse_we_i = 1'b1;
    @(negedge clk_i);
    coarse_we_i = 1'b0; fine_wdata_i = 6'(dl); fine_we_i = 1'b1;
    @(negedge clk_i);
    fine_we_i = 1'b0;
    @(negedge clk_i);
    check("R8 readback after fine write", int'(coarse_rdata_o), dh);
  endtask

  task automatic measure(int nfr, int dh0, int dl0, int dh1, int dl1, bit pol, int wr_at);
    int hi[64];
    int tot, bad, dh, dl, g;
    polarity_i = pol;
    count_stop_i = 1'b0;
    for (int f = 0; f < nfr; f++) begin
      dh = (f == 0) ? dh0 : dh1;
      dl = (f == 0) ? dl0 : dl1;
      for (int m = 0; m < 64; m++) hi[m] = 0;
      tot = 0;
      for (int u = 0; u < FRAME; u++) begin
        @(posedge clk_i);
        @(negedge clk_i);
        g = f * FRAME + u;
        if (dac_o ^ pol) begin hi[u >> 8]++; tot++; end
        if (wr_at >= 0) begin
          if (g == wr_at) begin
            coarse_wdata_i = 8'(dh1); coarse_we_i = 1'b1;
          end else if (g == wr_at + 1) begin
            check("R7 lone coarse write keeps readback", int'(coarse_rdata_o), dh0);
            coarse_we_i = 1'b0; fine_wdata_i = 6'(dl1); fine_we_i = 1'b1;
          end else if (g == wr_at + 2) begin
            check("R8 readback shows staged coarse", int'(coarse_rdata_o), dh1);
            fine_we_i = 1'b0;
          end
        end
      end
      bad = 0;
      for (int m = 0; m < 64; m++)
        if (hi[m] != exp_sub(dh, dl, m)) begin
          if (bad == 0)
            $display("FAIL R3/R4 sub %0d actual=%0d expected=%0d", m, hi[m], exp_sub(dh, dl, m));
          bad++;
        end
      check("R3 R4 R9 R11 per-sub active time mismatches", bad, 0);
      if (dh < 255) check("R5 frame total", tot, 64 * dh + dl);
      else          check("R6 frame total clipped", tot, 64 * 255);
    end
    count_stop_i = 1'b1;
    @(negedge clk_i);
    check("R10 idle level after stop", int'(dac_o), int'(pol));
  endtask

  initial begin
    int a, b, c, d;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk_i);
    check("R1 reset output", int'(dac_o), 0);
    check("R1 reset readback", int'(coarse_rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    load(0, 1);     measure(1, 0, 1, 0, 1, 1'b0, -1);
    load(255, 63);  measure(1, 255, 63, 255, 63, 1'b0, -1);
    a = $urandom_range(254, 0); b = $urandom_range(63, 0);
    load(a, b);     measure(1, a, b, a, b, 1'b0, -1);
    a = $urandom_range(254, 1); b = $urandom_range(63, 0);
    c = (a + 97) % 255;         d = $urandom_range(63, 0);
    load(a, b);     measure(2, a, b, c, d, 1'b0, 5000);
    a = $urandom_range(254, 0); b = $urandom_range(63, 0);
    load(a, b);     measure(1, a, b, a, b, 1'b1, -1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * 8);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule